// File: doc/BRIEF.md
# Command and Status Register Pair with Board Reset Sequencer

This block sits behind a simple register bus and gives software two byte-wide locations. The location selected with the address bit low is a read/write command byte. Some of its bits fire a one-cycle action when they go from 0 to 1. The others hold a level for as long as they stay at 1. The location selected with the address bit high is a read-only status byte. It reports the accept line, sticky error and busy flags, the front-end reset state and the calibration-busy line.

The block also sequences the board-wide reset. The power-on reset input, a command bit and a debounced pushbutton can each start it. Every source gives a single cycle of `sys_rst_o`. That cycle clears the command byte and the sticky flags. It also pulls the active-low front-end reset output low, unless a strap input is tied low. The block ORs every busy source into one busy output for the trigger logic around it.

Top module: `cmdstat_ctrl`

## Requirements
- R1: With the address bit at 0, a write stores the data into the command byte. A read returns that byte with bit 5 always 0. With the address bit at 1, a read returns the status byte and a write changes nothing. Read data is registered and appears in the cycle after the clock edge that samples the read strobe.
- R2: Command bit 0 (trigger) and bit 4 (calibrate) each give exactly one cycle on `trig_pulse_o` / `cal_pulse_o`, in the cycle after the write edge that turns the stored bit from 0 to 1. Writing 1 again, or leaving the bit at 1, gives no further pulse.
- R3: While command bit 2 is 1, `busy_o` is high. While bit 3 is 1, `fe_rst_n_o` is low. While bit 6 is 1, `var_trig_o` is high. Each drops in the cycle after 0 is written.
- R4: Status byte layout: bit 0 = `accept_i`, bit 1 = sticky error, bit 2 = sticky busy, bit 3 = 1 while `fe_rst_n_o` is low, bit 4 = `cal_busy_i`, bits 7..5 = 0.
- R5: `busy_o` is the OR of `int_busy_i`, `cal_busy_i`, every bit of `ext_busy_i` and command bit 2.
- R6: `sys_rst_o` is high for one cycle in each of these cases: the first cycle after `rst_n` is released; the second cycle after a write edge that sets command bit 7 from 0; once per press of `btn_rst_i`, after its BTN_SYNC-stage synchroniser, however long the button is held.
- R7: While `sys_rst_o` is high and `fe_rst_strap_i` is 1, `fe_rst_n_o` is low.
- R8: With `fe_rst_strap_i` at 0, `sys_rst_o` does not pull `fe_rst_n_o` low. Command bit 3 still does.
- R9: The cycle of `sys_rst_o` clears the whole command byte and both sticky flags. A bus write in that cycle is discarded.
- R10: The sticky error flag (`error_o`, status bit 1) is set by any `ext_err_i` bit or by command bit 1. The sticky busy flag (status bit 2) is set by any `ext_busy_i` bit or by command bit 2. Only a reset clears either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 1 | 0 selects the command byte, 1 selects the status byte |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| ext_busy_i | input | BUSY_SRCS | External busy requests |
| ext_err_i | input | ERR_SRCS | External error requests |
| int_busy_i | input | 1 | Busy raised by the trigger logic on the board |
| accept_i | input | 1 | Accept line, mirrored in status |
| cal_busy_i | input | 1 | Calibration-busy line |
| btn_rst_i | input | 1 | Asynchronous reset pushbutton, active high |
| fe_rst_strap_i | input | 1 | 0 stops the board reset from reaching the front-end reset |
| trig_pulse_o | output | 1 | One-cycle trigger command |
| cal_pulse_o | output | 1 | One-cycle calibrate command |
| var_trig_o | output | 1 | Variable-length trigger mode level |
| error_o | output | 1 | Sticky error flag |
| busy_o | output | 1 | Combined busy |
| sys_rst_o | output | 1 | One-cycle board reset |
| fe_rst_n_o | output | 1 | Active-low front-end reset |

## Verification
The bench builds the block with three external error sources, two external busy sources and a three-stage pushbutton synchroniser. These values differ from the defaults. They show that the OR reductions respond to a source other than bit 0. They also show that the button pulse stays a single cycle when the path through the synchroniser is longer. The bench counts reset and front-end reset cycles over a window that spans a long button press. It does this once for each strap value, which exercises the strap masking and the single-pulse rule.

// File: rtl/cmdstat_pkg.sv
// Package: shared bit positions and selector type for the command/status block.
// Assumes an 8-bit register width; bit positions are decoded by software.
package cmdstat_pkg;

    localparam int REG_W = 8;

    // Command byte bit positions
    localparam int CB_TRIG  = 0;
    localparam int CB_ERR   = 1;
    localparam int CB_BUSY  = 2;
    localparam int CB_FERST = 3;
    localparam int CB_CAL   = 4;
    localparam int CB_SPARE = 5;
    localparam int CB_VART  = 6;
    localparam int CB_GLB   = 7;

    // Status byte bit positions
    localparam int SB_ACC   = 0;
    localparam int SB_ERR   = 1;
    localparam int SB_BUSY  = 2;
    localparam int SB_FERST = 3;
    localparam int SB_CALB  = 4;

    // Bits of the command byte that hold storage
    localparam logic [REG_W-1:0] CMD_STORE_MASK = ~(REG_W'(1) << CB_SPARE);

    typedef enum logic {
        SEL_CMD  = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    // Assemble the status byte from its live and sticky sources
    function automatic logic [REG_W-1:0] pack_status(
        input logic acc,
        input logic err,
        input logic busy,
        input logic ferst,
        input logic calb
    );
        logic [REG_W-1:0] v;
        v           = '0;
        v[SB_ACC]   = acc;
        v[SB_ERR]   = err;
        v[SB_BUSY]  = busy;
        v[SB_FERST] = ferst;
        v[SB_CALB]  = calb;
        return v;
    endfunction

endpackage

// File: rtl/cmdstat_cmdreg.sv
// Module: command byte storage and single-shot edge detection.
// Assumes: wr_i is already qualified with the command address; clr_i is the
// one-cycle board reset and wins over any write in the same cycle.
module cmdstat_cmdreg
    import cmdstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] cmd_o,
    output logic             trig_shot_o,
    output logic             cal_shot_o,
    output logic             glb_shot_o
);

    localparam int N_SHOT = 3;

    logic [REG_W-1:0]  cmd_q;
    logic [N_SHOT-1:0] prev_q;
    logic [N_SHOT-1:0] cur_w;
    logic [N_SHOT-1:0] shot_w;

    // Store the written byte; reset and board clear both empty it
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cmd_q <= '0;
        end else if (wr_i) begin
            cmd_q <= wdata_i & CMD_STORE_MASK;
        end
    end

    assign cur_w = {cmd_q[CB_GLB], cmd_q[CB_CAL], cmd_q[CB_TRIG]};

    // Remember last cycle's single-shot bits for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            prev_q <= '0;
        end else begin
            prev_q <= cur_w;
        end
    end

    assign shot_w      = cur_w & ~prev_q;
    assign trig_shot_o = shot_w[0];
    assign cal_shot_o  = shot_w[1];
    assign glb_shot_o  = shot_w[2];
    assign cmd_o       = cmd_q;

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_shot_o |=> !trig_shot_o); // R2

    AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_shot_o |=> !cal_shot_o); // R2

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cmd_o == '0)); // R9

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !cmd_o[CB_SPARE]); // R1

endmodule

// File: rtl/cmdstat_rstgen.sv
// Module: board reset sequencer and front-end reset driver.
// Assumes: btn_i is asynchronous and is synchronised here over BTN_SYNC
// flops; glb_shot_i is a one-cycle pulse. Each source yields one reset cycle.
module cmdstat_rstgen #(
    parameter int BTN_SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic glb_shot_i,
    input  logic btn_i,
    input  logic strap_i,
    input  logic fe_cmd_i,
    output logic sys_rst_o,
    output logic fe_act_o
);

    logic [BTN_SYNC-1:0] sync_q;
    logic                btn_q;
    logic                btn_rise;
    logic                gr_q;

    // Pushbutton synchroniser; the structure depends on its depth
    generate
        if (BTN_SYNC == 1) begin : g_sync_one
            // Single-flop capture of the button
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= btn_i;
            end
        end else begin : g_sync_chain
            // Shift the button through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[BTN_SYNC-2:0], btn_i};
            end
        end
    endgenerate

    // Hold the synchronised level to find the press edge
    always_ff @(posedge clk) begin
        if (!rst_n) btn_q <= 1'b0;
        else        btn_q <= sync_q[BTN_SYNC-1];
    end

    assign btn_rise = sync_q[BTN_SYNC-1] & ~btn_q;

    // Reset cycle: held through power-on, then one cycle per request
    always_ff @(posedge clk) begin
        if (!rst_n) gr_q <= 1'b1;
        else        gr_q <= glb_shot_i | btn_rise;
    end

    assign sys_rst_o = gr_q;
    assign fe_act_o  = fe_cmd_i | (gr_q & strap_i);

    AST_RST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_shot_i || btn_rise) |=> sys_rst_o); // R6

    AST_PRESS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        btn_rise |=> !btn_rise); // R6

    AST_STRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_i && !fe_cmd_i && sys_rst_o) |-> !fe_act_o); // R8

endmodule

// File: rtl/cmdstat_status.sv
// Module: sticky error/busy flags, combined busy and registered read mux.
// Assumes: clr_i is the one-cycle board reset; the status byte is read-only.
module cmdstat_status
    import cmdstat_pkg::*;
#(
    parameter int BUSY_SRCS = 1,
    parameter int ERR_SRCS  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 rd_i,
    input  reg_sel_e             sel_i,
    input  logic [REG_W-1:0]     cmd_i,
    input  logic [BUSY_SRCS-1:0] ext_busy_i,
    input  logic [ERR_SRCS-1:0]  ext_err_i,
    input  logic                 int_busy_i,
    input  logic                 accept_i,
    input  logic                 cal_busy_i,
    input  logic                 fe_act_i,
    output logic [REG_W-1:0]     rdata_o,
    output logic                 busy_o,
    output logic                 err_o
);

    logic             err_q;
    logic             busy_q;
    logic             err_req;
    logic             busy_req;
    logic [REG_W-1:0] stat_w;
    logic [REG_W-1:0] rdata_q;

    assign err_req  = (|ext_err_i)  | cmd_i[CB_ERR];
    assign busy_req = (|ext_busy_i) | cmd_i[CB_BUSY];

    // Sticky flags: set by any request, cleared only by a reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            err_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            err_q  <= err_q  | err_req;
            busy_q <= busy_q | busy_req;
        end
    end

    assign busy_o = busy_req | int_busy_i | cal_busy_i;
    assign err_o  = err_q;
    assign stat_w = pack_status(accept_i, err_q, busy_q, fe_act_i, cal_busy_i);

    // Capture the selected byte on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= (sel_i == SEL_STAT) ? stat_w : cmd_i;
        end
    end

    assign rdata_o = rdata_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_i) |=> err_q); // R10

    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !clr_i) |=> busy_q); // R10

    AST_STAT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_i == SEL_STAT) |=> (rdata_o[REG_W-1:SB_CALB+1] == '0)); // R4

endmodule

// File: rtl/cmdstat_ctrl.sv
// Module: top of the command/status register pair with reset control.
// Assumes: single-cycle bus strobes, write and read never both high for the
// same location in one cycle; btn_rst_i may be asynchronous.
module cmdstat_ctrl
    import cmdstat_pkg::*;
#(
    parameter int BUSY_SRCS = 1,
    parameter int ERR_SRCS  = 1,
    parameter int BTN_SYNC  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic                 bus_addr_i,
    input  logic [7:0]           bus_wdata_i,
    output logic [7:0]           bus_rdata_o,
    input  logic [BUSY_SRCS-1:0] ext_busy_i,
    input  logic [ERR_SRCS-1:0]  ext_err_i,
    input  logic                 int_busy_i,
    input  logic                 accept_i,
    input  logic                 cal_busy_i,
    input  logic                 btn_rst_i,
    input  logic                 fe_rst_strap_i,
    output logic                 trig_pulse_o,
    output logic                 cal_pulse_o,
    output logic                 var_trig_o,
    output logic                 error_o,
    output logic                 busy_o,
    output logic                 sys_rst_o,
    output logic                 fe_rst_n_o
);

    reg_sel_e         sel_w;
    logic             cmd_wr;
    logic [REG_W-1:0] cmd_w;
    logic             glb_shot;
    logic             clr_w;
    logic             fe_act;

    assign sel_w  = reg_sel_e'(bus_addr_i);
    assign cmd_wr = bus_wr_i && (sel_w == SEL_CMD);

    cmdstat_cmdreg u_cmdreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_w),
        .wr_i        (cmd_wr),
        .wdata_i     (bus_wdata_i),
        .cmd_o       (cmd_w),
        .trig_shot_o (trig_pulse_o),
        .cal_shot_o  (cal_pulse_o),
        .glb_shot_o  (glb_shot)
    );

    cmdstat_rstgen #(
        .BTN_SYNC (BTN_SYNC)
    ) u_rstgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .glb_shot_i (glb_shot),
        .btn_i      (btn_rst_i),
        .strap_i    (fe_rst_strap_i),
        .fe_cmd_i   (cmd_w[CB_FERST]),
        .sys_rst_o  (clr_w),
        .fe_act_o   (fe_act)
    );

    cmdstat_status #(
        .BUSY_SRCS (BUSY_SRCS),
        .ERR_SRCS  (ERR_SRCS)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_w),
        .rd_i       (bus_rd_i),
        .sel_i      (sel_w),
        .cmd_i      (cmd_w),
        .ext_busy_i (ext_busy_i),
        .ext_err_i  (ext_err_i),
        .int_busy_i (int_busy_i),
        .accept_i   (accept_i),
        .cal_busy_i (cal_busy_i),
        .fe_act_i   (fe_act),
        .rdata_o    (bus_rdata_o),
        .busy_o     (busy_o),
        .err_o      (error_o)
    );

    assign var_trig_o = cmd_w[CB_VART];
    assign sys_rst_o  = clr_w;
    assign fe_rst_n_o = ~fe_act;

    AST_FE_DURING_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_o && fe_rst_strap_i) |-> !fe_rst_n_o); // R7

    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i && !sys_rst_o) |=> $stable(var_trig_o)); // R1

endmodule

// File: tb/cmdstat_ctrl_tb.sv
`timescale 1ns/1ps
module cmdstat_ctrl_tb;

    localparam int BUSY_SRCS = 2;
    localparam int ERR_SRCS  = 3;
    localparam int BTN_SYNC  = 3;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 bus_wr, bus_rd, bus_addr;
    logic [7:0]           bus_wdata;
    logic [7:0]           bus_rdata;
    logic [BUSY_SRCS-1:0] ext_busy;
    logic [ERR_SRCS-1:0]  ext_err;
    logic                 int_busy, accept, cal_busy, btn, strap;
    logic                 trig_p, cal_p, var_trig, error, busy, sys_rst, fe_rst_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cmdstat_ctrl #(
        .BUSY_SRCS (BUSY_SRCS),
        .ERR_SRCS  (ERR_SRCS),
        .BTN_SYNC  (BTN_SYNC)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wr_i       (bus_wr),
        .bus_rd_i       (bus_rd),
        .bus_addr_i     (bus_addr),
        .bus_wdata_i    (bus_wdata),
        .bus_rdata_o    (bus_rdata),
        .ext_busy_i     (ext_busy),
        .ext_err_i      (ext_err),
        .int_busy_i     (int_busy),
        .accept_i       (accept),
        .cal_busy_i     (cal_busy),
        .btn_rst_i      (btn),
        .fe_rst_strap_i (strap),
        .trig_pulse_o   (trig_p),
        .cal_pulse_o    (cal_p),
        .var_trig_o     (var_trig),
        .error_o        (error),
        .busy_o         (busy),
        .sys_rst_o      (sys_rst),
        .fe_rst_n_o     (fe_rst_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Reset release: one reset cycle with front-end pulse, then empty registers
    task automatic t_power_on();
        logic [7:0] d;
        rst_n = 1'b0;
        repeat (5) tick();
        rst_n = 1'b1;
        check("R6", "sys_rst after release", sys_rst, 1);
        check("R7", "fe_rst_n during power-on reset", fe_rst_n, 0);
        tick();
        check("R6", "sys_rst one cycle only", sys_rst, 0);
        check("R7", "fe_rst_n released", fe_rst_n, 1);
        bus_read(1'b0, d);
        check("R1", "command byte after reset", d, 8'h00);
        bus_read(1'b1, d);
        check("R4", "status byte after reset", d, 8'h00);
        check("R2", "no trigger after reset", trig_p, 0);
        check("R5", "busy idle after reset", busy, 0);
    endtask

    // Single-shot trigger and calibrate bits
    task automatic t_single_shot();
        bus_write(1'b0, 8'h01);
        check("R2", "trigger pulse on 0->1", trig_p, 1);
        tick();
        check("R2", "trigger pulse ends", trig_p, 0);
        bus_write(1'b0, 8'h01);
        check("R2", "rewrite 1 gives no trigger", trig_p, 0);
        tick();
        check("R2", "held 1 gives no trigger", trig_p, 0);
        bus_write(1'b0, 8'h00);
        bus_write(1'b0, 8'h01);
        check("R2", "trigger after return to 0", trig_p, 1);
        bus_write(1'b0, 8'h10);
        check("R2", "calibrate pulse", cal_p, 1);
        check("R2", "no trigger with bit 0 cleared", trig_p, 0);
        tick();
        check("R2", "calibrate pulse ends", cal_p, 0);
        bus_write(1'b0, 8'h00);
    endtask

    // Level bits, readback masking and sticky flags
    task automatic t_levels();
        logic [7:0] d;
        bus_write(1'b0, 8'h6E);
        check("R3", "var_trig level", var_trig, 1);
        check("R3", "fe_rst_n from command", fe_rst_n, 0);
        check("R3", "busy from command", busy, 1);
        tick();
        check("R10", "error sticky set by command", error, 1);
        bus_read(1'b0, d);
        check("R1", "command readback drops bit 5", d, 8'h4E);
        bus_read(1'b1, d);
        check("R4", "status with levels", d, 8'h0E);
        bus_write(1'b0, 8'h00);
        check("R3", "var_trig drops", var_trig, 0);
        check("R3", "fe_rst_n releases", fe_rst_n, 1);
        check("R3", "busy drops", busy, 0);
        bus_read(1'b1, d);
        check("R10", "sticky flags survive clear", d, 8'h06);
    endtask

    // Command-started board reset, including a write discarded in its cycle
    task automatic t_global(input logic s);
        logic [7:0] d;
        strap = s;
        bus_write(1'b0, 8'h80);
        check("R6", "no reset in shot cycle", sys_rst, 0);
        tick();
        check("R6", "reset follows command", sys_rst, 1);
        check(s ? "R7" : "R8", "fe_rst_n during command reset", fe_rst_n, s ? 0 : 1);
        bus_write(1'b0, 8'h44);
        check("R6", "reset lasts one cycle", sys_rst, 0);
        check("R9", "write during reset discarded", var_trig, 0);
        bus_read(1'b0, d);
        check("R9", "command byte cleared", d, 8'h00);
        bus_read(1'b1, d);
        check("R9", "sticky flags cleared", d, 8'h00);
        strap = 1'b1;
    endtask

    // Busy sources and live status bits
    task automatic t_busy_status();
        logic [7:0] d;
        accept = 1'b1; cal_busy = 1'b1;
        bus_read(1'b1, d);
        check("R4", "live accept and calibrate-busy", d, 8'h11);
        check("R5", "busy from calibrate-busy", busy, 1);
        accept = 1'b0; cal_busy = 1'b0;
        int_busy = 1'b1;
        tick();
        check("R5", "busy from internal source", busy, 1);
        int_busy = 1'b0;
        tick();
        check("R5", "busy idle", busy, 0);
        ext_busy = 2'b10;
        tick();
        check("R5", "busy from external source 1", busy, 1);
        ext_busy = '0;
        tick();
        bus_read(1'b1, d);
        check("R10", "sticky busy from external", d, 8'h04);
        bus_write(1'b1, 8'h4C);
        bus_read(1'b0, d);
        check("R1", "status write ignored", d, 8'h00);
        check("R1", "status write leaves var_trig", var_trig, 0);
        ext_err = 3'b100;
        tick();
        ext_err = '0;
        repeat (3) tick();
        check("R10", "error sticky from external source 2", error, 1);
    endtask

    // Pushbutton reset with a long press, counting reset and front-end cycles
    task automatic t_button(input logic s);
        logic [7:0] d;
        int n_rst = 0;
        int n_fe  = 0;
        strap = s;
        btn = 1'b1;
        for (int i = 0; i < 14; i++) begin
            if (i == 8) btn = 1'b0;
            tick();
            if (sys_rst) n_rst++;
            if (!fe_rst_n) n_fe++;
        end
        check("R6", "one reset cycle per press", n_rst, 1);
        check(s ? "R7" : "R8", "front-end reset cycles per press", n_fe, s ? 1 : 0);
        bus_read(1'b1, d);
        check("R9", "button reset clears sticky flags", d, 8'h00);
        if (!s) begin
            bus_write(1'b0, 8'h08);
            check("R8", "command fe reset with strap low", fe_rst_n, 0);
            bus_write(1'b0, 8'h00);
            check("R8", "command fe reset released", fe_rst_n, 1);
        end
        strap = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
        ext_busy = '0; ext_err = '0; int_busy = 1'b0; accept = 1'b0; cal_busy = 1'b0;
        btn = 1'b0; strap = 1'b1;
        t_power_on();
        t_single_shot();
        t_levels();
        t_global(1'b1);
        t_busy_status();
        t_button(1'b1);
        bus_write(1'b0, 8'h06);
        tick();
        t_button(1'b0);
        t_global(1'b0);
        summary();
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule